// File: doc/BRIEF.md
# Integer ALU with Logical Shifts

This block is the integer execute unit of a simple 32-bit load/store processor. On each operation it takes two register operands, a separate shift-distance field taken straight from the instruction word, and the 6-bit function code of a register-register instruction. It returns a result word, a flag that is high when that result is zero, and a flag that marks a function code it does not implement.

The function-code decoder sits inside the block, so the unit can be driven directly from instruction fields. The operations are add, subtract, AND, OR, NOR, signed and unsigned set-less-than, and logical shifts left and right. NOR is the only inverting operation: a bitwise NOT is NOR with a zero operand. Both shifts move operand B by the shift-distance field and fill the vacated bits with zeros. The output stage can be a register for timing, or it can be plain wiring.

Top module: `int_alu`

## Requirements
- R1: While rst_n is low, with the registered output stage (the default), result_o is 0, zero_o is 1 and illegal_o is 0.
- R2: Function code 32 gives A+B modulo 2^32. Function code 34 gives A-B modulo 2^32.
- R3: Function code 36 gives the bitwise AND of A and B, and function code 37 gives their bitwise OR. For example, 0x00000DC0 AND 0x00003C00 = 0x00000C00, and the OR of the same pair is 0x00003DC0.
- R4: Function code 39 gives NOT(A OR B). With B = 0 this is the bitwise NOT of A.
- R5: Function code 0 gives B shifted left by shamt_i, and function code 2 gives B shifted right by shamt_i. Both fill vacated bits with zero. Operand A has no effect on either shift.
- R6: Function code 42 gives 1 when A < B as two's-complement numbers, else 0. Function code 43 gives 1 when A < B as unsigned numbers, else 0. With A = 0xFFFFFFFF and B = 1, code 42 gives 1 and code 43 gives 0.
- R7: zero_o is 1 exactly when result_o is 0.
- R8: Any function code other than 0, 2, 32, 34, 36, 37, 39, 42 and 43 gives result_o = 0 and illegal_o = 1. Each supported code gives illegal_o = 0.
- R9: With the registered output stage, the outputs after a rising clock edge reflect the inputs present at that edge, which is a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| funct_i | input | 6 | Function code of the register-register instruction |
| shamt_i | input | 5 | Shift distance from the instruction field |
| a_i | input | 32 | Operand A (first source register) |
| b_i | input | 32 | Operand B (second source register, also the shift source) |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is zero |
| illegal_o | output | 1 | High for an unsupported function code |

## Verification
The checks inside the shifter take for granted that the shift amount is always narrower than the word. This holds because the amount port is log2 of the data width wide. They also take for granted that the direction select is meaningful only for the two shift codes. The clocked output checks assume inputs settle between clock edges. The stimulus meets this by changing funct_i, shamt_i and the operands only on the falling edge. Stimulus walks every supported code, several unsupported codes and wrap-around and sign-boundary operands. It then applies a long run of mixed random codes and operands.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   localparam int FUNCT_W = 6;

   localparam logic [FUNCT_W-1:0] FN_SLL  = 6'd0;
   localparam logic [FUNCT_W-1:0] FN_SRL  = 6'd2;
   localparam logic [FUNCT_W-1:0] FN_ADD  = 6'd32;
   localparam logic [FUNCT_W-1:0] FN_SUB  = 6'd34;
   localparam logic [FUNCT_W-1:0] FN_AND  = 6'd36;
   localparam logic [FUNCT_W-1:0] FN_OR   = 6'd37;
   localparam logic [FUNCT_W-1:0] FN_NOR  = 6'd39;
   localparam logic [FUNCT_W-1:0] FN_SLT  = 6'd42;
   localparam logic [FUNCT_W-1:0] FN_SLTU = 6'd43;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_ADD,
      OP_SUB,
      OP_AND,
      OP_OR,
      OP_NOR,
      OP_SLT,
      OP_SLTU,
      OP_SLL,
      OP_SRL
   } alu_op_e;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
   import int_alu_pkg::*;
(
   input  logic [FUNCT_W-1:0] funct_i,
   output alu_op_e            op_o,
   output logic               illegal_o
);

   always_comb begin
      illegal_o = 1'b0;
      unique case (funct_i)
         FN_ADD:  op_o = OP_ADD;
         FN_SUB:  op_o = OP_SUB;
         FN_AND:  op_o = OP_AND;
         FN_OR:   op_o = OP_OR;
         FN_NOR:  op_o = OP_NOR;
         FN_SLT:  op_o = OP_SLT;
         FN_SLTU: op_o = OP_SLTU;
         FN_SLL:  op_o = OP_SLL;
         FN_SRL:  op_o = OP_SRL;
         default: begin
            op_o      = OP_NONE;
            illegal_o = 1'b1;
         end
      endcase
   end

   // R8: the illegal flag and the "no operation" selection travel together
   always_comb begin
      a_r8_flag_matches_op: assert (illegal_o == (op_o == OP_NONE));
   end

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = $clog2(DATA_W),
   parameter bit BARREL  = 1'b1
) (
   input  logic [DATA_W-1:0]  val_i,
   input  logic [SHAMT_W-1:0] amt_i,
   input  logic               right_i,
   output logic [DATA_W-1:0]  res_o
);

   localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

   generate
      if (BARREL) begin : g_barrel
         logic [DATA_W-1:0] stg [SHAMT_W+1];
         logic [DATA_W-1:0] pre;
         for (genvar j = 0; j < DATA_W; j++) begin : g_rev_in
            assign pre[j] = right_i ? val_i[DATA_W-1-j] : val_i[j];
         end
         assign stg[0] = pre;
         for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
            assign stg[s+1] = amt_i[s] ? (stg[s] << (2**s)) : stg[s];
         end
         for (genvar j = 0; j < DATA_W; j++) begin : g_rev_out
            assign res_o[j] = right_i ? stg[SHAMT_W][DATA_W-1-j]
                                      : stg[SHAMT_W][j];
         end
      end else begin : g_plain
         assign res_o = right_i ? (val_i >> amt_i) : (val_i << amt_i);
      end
   endgenerate

   // R5: vacated positions always read as zero
   always_comb begin
      if (right_i) begin
         a_r5_fill_right: assert ((res_o & ~(ONES >> amt_i)) == '0);
      end else begin
         a_r5_fill_left: assert ((res_o & ~(ONES << amt_i)) == '0);
      end
   end

endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
   import int_alu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = $clog2(DATA_W),
   parameter bit BARREL  = 1'b1
) (
   input  alu_op_e            op_i,
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   output logic [DATA_W-1:0]  res_o
);

   localparam int MSB = DATA_W - 1;

   logic              do_sub;
   logic [DATA_W:0]   sum_ext;
   logic [DATA_W-1:0] b_eff;
   logic              lt_u;
   logic              lt_s;
   logic [DATA_W-1:0] sh_res;

   assign do_sub  = (op_i != OP_ADD);
   assign b_eff   = do_sub ? ~b_i : b_i;
   assign sum_ext = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
   // carry out of A + ~B + 1 is set when A >= B (unsigned)
   assign lt_u    = ~sum_ext[DATA_W];
   assign lt_s    = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : lt_u;

   int_alu_shift #(
      .DATA_W (DATA_W),
      .SHAMT_W(SHAMT_W),
      .BARREL (BARREL)
   ) shift_i (
      .val_i  (b_i),
      .amt_i  (shamt_i),
      .right_i(op_i == OP_SRL),
      .res_o  (sh_res)
   );

   always_comb begin
      unique case (op_i)
         OP_ADD, OP_SUB: res_o = sum_ext[DATA_W-1:0];
         OP_AND:         res_o = a_i & b_i;
         OP_OR:          res_o = a_i | b_i;
         OP_NOR:         res_o = ~(a_i | b_i);
         OP_SLT:         res_o = {{(DATA_W-1){1'b0}}, lt_s};
         OP_SLTU:        res_o = {{(DATA_W-1){1'b0}}, lt_u};
         OP_SLL, OP_SRL: res_o = sh_res;
         default:        res_o = '0;
      endcase
   end

   // R6: comparison results agree with the language's own ordering
   always_comb begin
      if (op_i == OP_SLTU) begin
         a_r6_unsigned_cmp: assert (res_o[0] == (a_i < b_i));
      end
      if (op_i == OP_SLT) begin
         a_r6_signed_cmp: assert (res_o[0] == ($signed(a_i) < $signed(b_i)));
      end
   end

endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = $clog2(DATA_W),
   parameter bit BARREL  = 1'b1,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FUNCT_W-1:0] funct_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   output logic [DATA_W-1:0]  result_o,
   output logic               zero_o,
   output logic               illegal_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("int_alu: DATA_W must be at least 2");
      end
      if ((2**SHAMT_W) != DATA_W) begin : g_bad_shamt
         $error("int_alu: DATA_W must equal 2**SHAMT_W");
      end
   endgenerate

   alu_op_e           op;
   logic              ill_c;
   logic [DATA_W-1:0] res_c;
   logic              zero_c;

   int_alu_decode decode_i (
      .funct_i  (funct_i),
      .op_o     (op),
      .illegal_o(ill_c)
   );

   int_alu_core #(
      .DATA_W (DATA_W),
      .SHAMT_W(SHAMT_W),
      .BARREL (BARREL)
   ) core_i (
      .op_i   (op),
      .a_i    (a_i),
      .b_i    (b_i),
      .shamt_i(shamt_i),
      .res_o  (res_c)
   );

   assign zero_c = (res_c == '0);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               result_o  <= '0;
               zero_o    <= 1'b1;
               illegal_o <= 1'b0;
            end else begin
               result_o  <= res_c;
               zero_o    <= zero_c;
               illegal_o <= ill_c;
            end
         end

         // R7: registered flag stays consistent with registered result
         a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
            ##1 (zero_o == (result_o == '0)));
         // R8: an unsupported code never leaves a stale result visible
         a_r8_illegal_clear: assert property (@(posedge clk) disable iff (!rst_n)
            ill_c |=> (result_o == '0) && illegal_o);
         // R5: A plays no part in a left shift
         a_r5_shift_ignores_a: assert property (@(posedge clk) disable iff (!rst_n)
            (funct_i == FN_SLL) && (shamt_i == '0) |=> (result_o == $past(b_i)));
      end else begin : g_comb
         assign result_o  = res_c;
         assign zero_o    = zero_c;
         assign illegal_o = ill_c;
      end
   endgenerate

endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;

   typedef struct {
      logic [31:0] res;
      logic        ill;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  funct = 6'd32;
   logic [4:0]  shamt = 5'd0;
   logic [31:0] a = 32'h1234;
   logic [31:0] b = 32'h1;
   logic [31:0] result_o;
   logic        zero_o;
   logic        illegal_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   int_alu dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .funct_i  (funct),
      .shamt_i  (shamt),
      .a_i      (a),
      .b_i      (b),
      .result_o (result_o),
      .zero_o   (zero_o),
      .illegal_o(illegal_o)
   );

   function automatic void model(input logic [5:0] f, input logic [4:0] s,
                                 input logic [31:0] x, input logic [31:0] y,
                                 output logic [31:0] r, output logic il);
      il = 1'b0;
      case (f)
         6'd32: r = x + y;
         6'd34: r = x - y;
         6'd36: r = x & y;
         6'd37: r = x | y;
         6'd39: r = ~(x | y);
         6'd42: r = {31'd0, $signed(x) < $signed(y)};
         6'd43: r = {31'd0, x < y};
         6'd0:  r = y << s;
         6'd2:  r = y >> s;
         default: begin r = 32'd0; il = 1'b1; end
      endcase
   endfunction

   task automatic compare(input string tag, input logic [31:0] er, input logic ei);
      logic ez;
      ez = (er == 32'd0);
      checks++;
      if (result_o !== er || zero_o !== ez || illegal_o !== ei) begin
         errors++;
         $display("FAIL %s: got res=%h zero=%b ill=%b expected res=%h zero=%b ill=%b",
                  tag, result_o, zero_o, illegal_o, er, ez, ei);
      end
   endtask

   task automatic drive(input logic [5:0] f, input logic [4:0] s,
                        input logic [31:0] x, input logic [31:0] y,
                        input logic [31:0] er, input logic ei, input string tag);
      exp_t it;
      @(negedge clk);
      funct = f; shamt = s; a = x; b = y;
      it.res = er; it.ill = ei; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic drive_model(input logic [5:0] f, input logic [4:0] s,
                              input logic [31:0] x, input logic [31:0] y,
                              input string tag);
      logic [31:0] r;
      logic        il;
      model(f, s, x, y, r, il);
      drive(f, s, x, y, r, il, tag);
   endtask

   // monitor: one expected item per clock, sampled just after the edge (R9)
   always @(posedge clk) begin
      #1;
      if (rst_n && q.size() > 0) begin
         exp_t it;
         it = q.pop_front();
         compare(it.tag, it.res, it.ill);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 reset state", 32'd0, 1'b0);
      rst_n = 1'b1;

      drive(6'd32, 5'd0, 32'h11, 32'h22, 32'h33, 1'b0, "R2 add");
      drive(6'd32, 5'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b0, "R2 R7 add wrap zero");
      drive(6'd34, 5'd0, 32'h5, 32'h7, 32'hFFFF_FFFE, 1'b0, "R2 sub negative");
      drive(6'd34, 5'd0, 32'h9, 32'h9, 32'h0, 1'b0, "R2 R7 sub equal");
      drive(6'd36, 5'd0, 32'h0000_0DC0, 32'h0000_3C00, 32'h0000_0C00, 1'b0, "R3 and");
      drive(6'd37, 5'd0, 32'h0000_0DC0, 32'h0000_3C00, 32'h0000_3DC0, 1'b0, "R3 or");
      drive(6'd39, 5'd0, 32'h0000_3C00, 32'h0, 32'hFFFF_C3FF, 1'b0, "R4 nor as not");
      drive(6'd39, 5'd0, 32'hF0F0_0000, 32'h0F0F_0000, 32'h0000_FFFF, 1'b0, "R4 nor");
      drive(6'd0, 5'd31, 32'hDEAD_BEEF, 32'h1, 32'h8000_0000, 1'b0, "R5 sll 31");
      drive(6'd0, 5'd0, 32'hFFFF_FFFF, 32'hA5A5_0001, 32'hA5A5_0001, 1'b0, "R5 sll 0 ignores A");
      drive(6'd0, 5'd4, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 1'b0, "R5 sll zero fill");
      drive(6'd2, 5'd31, 32'h1234_5678, 32'h8000_0000, 32'h1, 1'b0, "R5 srl 31");
      drive(6'd2, 5'd8, 32'h0, 32'hFFFF_FFFF, 32'h00FF_FFFF, 1'b0, "R5 srl zero fill");
      drive(6'd2, 5'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h00FF_FFFF, 1'b0, "R5 srl ignores A");
      drive(6'd42, 5'd0, 32'hFFFF_FFFF, 32'h1, 32'h1, 1'b0, "R6 slt signed");
      drive(6'd43, 5'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b0, "R6 R7 sltu unsigned");
      drive(6'd42, 5'd0, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0, 1'b0, "R6 slt boundary");
      drive(6'd43, 5'd0, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1, 1'b0, "R6 sltu boundary");
      drive(6'd42, 5'd0, 32'h5, 32'h5, 32'h0, 1'b0, "R6 slt equal");
      drive(6'd63, 5'd3, 32'hFFFF, 32'hFFFF, 32'h0, 1'b1, "R8 code 63");
      drive(6'd1, 5'd1, 32'h1, 32'h1, 32'h0, 1'b1, "R8 code 1");
      drive(6'd33, 5'd0, 32'h1, 32'h1, 32'h0, 1'b1, "R8 code 33");
      drive(6'd32, 5'd0, 32'h1, 32'h1, 32'h2, 1'b0, "R8 R9 legal after illegal");

      for (int i = 0; i < 400; i++) begin
         logic [5:0] f;
         logic [3:0] pick;
         pick = 4'($urandom_range(0, 9));
         case (pick)
            4'd0: f = 6'd32; 4'd1: f = 6'd34; 4'd2: f = 6'd36;
            4'd3: f = 6'd37; 4'd4: f = 6'd39; 4'd5: f = 6'd42;
            4'd6: f = 6'd43; 4'd7: f = 6'd0;  4'd8: f = 6'd2;
            default: f = 6'($urandom);
         endcase
         drive_model(f, 5'($urandom), $urandom, $urandom, "R9 random mix");
      end

      repeat (3) @(negedge clk);
      if (q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL R9: got %0d pending expected 0", q.size());
      end
      finish_run();
   end

endmodule